// File: doc/BRIEF.md
# Two-Wire Sector-Program Memory Slave

This block is a slave on a two-wire serial bus that fronts a byte-wide memory held inside the design as a synchronous RAM. It samples the clock and data lines with the system clock, cleans them through a synchronizer and a glitch filter, and detects bus start and stop events. A master addresses it with a device byte: a fixed type nibble, a three-bit select code matched against three strap inputs, and a direction bit. A write then sends a high and a low address byte. Data bytes that follow are collected into a 32-byte sector buffer. The stop that ends the write launches a self-timed write cycle, during which the slave ignores the bus.

Reads return bytes from an internal address counter that walks the whole array and wraps to zero. A read starts either at the counter's current value or, after a write of just the address bytes, at a freshly loaded address. The all-ones 16-bit address selects a protection value that comes in on a port. Whether a program may commit is decided outside: the block shows the target sector and samples an allow input when the stop arrives. The data line is driven only as an open-drain pull-down enable.

Top module: `tw_sector_slave`

## Requirements
- R1: A device byte with 1010 in bits 7:4 and bits 3:1 equal to `sel_i` is acknowledged; bit 0 set to 1 means read. Any other device byte gets no acknowledge, and the slave waits for the next start. After reset `sda_oe_o` is 0.
- R2: After a write device byte, the slave acknowledges a high address byte and then a low address byte. The array address is the low ADDR_W bits of {high, low}. A stop after the low byte loads the address counter only, and the next current-address read returns the byte at that address.
- R3: Every program data byte is acknowledged. It goes to offset (start offset + k) mod 32 of the sector given by address bits ADDR_W-1:5, and a later byte replaces an earlier one at the same offset. After the write, the counter points at the offset after the last byte, within the same sector.
- R4: A stop after at least one data byte, with `wr_allow_i` high, starts a write cycle of WR_CYCLES clocks. During that cycle the slave gives no acknowledge even to its own address and keeps `sda_oe_o` low. Once the cycle ends it acknowledges again and the written data reads back.
- R5: If `wr_allow_i` is low at the stop, no write cycle starts: the next address byte is acknowledged at once, and the memory is unchanged.
- R6: Each read byte is taken from the counter, and the counter then advances by one. The advance wraps from the last array address to 0, and a master acknowledge makes the slave send the next byte.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing further until the next start or stop.
- R8: A read at the all-ones 16-bit address FFFFh returns `prot_val_i` and leaves the counter at 0.
- R9: A start received in the middle of a program abandons it: no write cycle starts and the memory is unchanged.
- R10: A clock-line pulse shorter than FILT_LEN system clocks is not seen as a bus clock edge.
- R11: The slave changes `sda_oe_o` only while the filtered bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sel_i | input | 3 | Strap select code compared with device byte bits 3:1 |
| prot_val_i | input | 8 | Protection value returned by a read of address FFFFh |
| wr_allow_i | input | 1 | 1 lets the pending program commit, sampled at the stop |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| chk_sector_o | output | ADDR_W-5 | Sector number of the addressed location, for the external permission check |

## Verification
Each slave reaction to a bus clock fall (acknowledge drive, release, next data bit) shows on `sda_oe_o` about six system clocks later. That delay covers the two synchronizer flops, FILT_LEN filter stages and the state register. The bench therefore holds each bus clock phase for twelve system clocks and samples the data line only at the end of a high phase, when both the acknowledge and the data bits have settled. A write cycle starts about six clocks after the filtered stop and lasts WR_CYCLES clocks. A poll started right after the stop falls inside that window, and reads made after a wait of more than twice WR_CYCLES fall outside it. Data stability while the clock is high is checked at both ends of every high phase of a read.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT, S_WAIT
    } tw_state_e;

    localparam logic [3:0] DEV_TYPE  = 4'b1010;
    localparam int         OFF_W     = 5;
    localparam int         SECT_SIZE = 1 << OFF_W;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0]          sync_q, sync_d;
    logic [FILT_LEN-1:0] hist_q, hist_d;
    logic                out_q, out_d;

    always_comb begin
        sync_d = {sync_q[0], din};
        hist_d = {hist_q[FILT_LEN-2:0], sync_q[1]};
        out_d  = out_q;
        if (&hist_q)       out_d = 1'b1;
        else if (~|hist_q) out_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;

    // R10: a filtered change always follows the synchronized line value
    assert_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> (out_q == $past(sync_q[1], 2)));
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [W-1:0]             rdata,
    output logic                     rvalid,
    output logic                     any
);
    logic [W-1:0]     data_q [DEPTH];
    logic [DEPTH-1:0] vld_q, vld_d;

    always_comb begin
        vld_d = vld_q;
        if (clr)     vld_d = '0;
        else if (we) vld_d[widx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (we) data_q[widx] <= wdata;
    end

    assign rdata  = data_q[ridx];
    assign rvalid = vld_q[ridx];
    assign any    = |vld_q;

    // R3: loading a byte and discarding the page never coincide
    assert_wr_clr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && clr));
endmodule

// File: rtl/tw_sector_ram.sv
module tw_sector_ram #(
    parameter int AW = 10,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rd_q <= mem_q[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/tw_sector_slave.sv
module tw_sector_slave #(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 64,
    parameter int FILT_LEN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        sel_i,
    input  logic [7:0]        prot_val_i,
    input  logic              wr_allow_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-6:0] chk_sector_o
);
    import tw_pkg::*;

    localparam int SEC_W = ADDR_W - OFF_W;
    localparam int TMR_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        tw_state_e         st;
        logic [3:0]        cnt;
        logic              ackph;
        logic [7:0]        sh;
        logic              oe;
        logic [7:0]        hi;
        logic [ADDR_W-1:0] addr;
        logic              regsel;
        logic              mack;
        logic              busy;
        logic [TMR_W-1:0]  tmr;
        logic              sclp;
        logic              sdap;
    } tw_regs_t;

    tw_regs_t q, n;

    logic scl_f, sda_f;
    logic rise, fall, start_ev, stop_ev, dev_hit, do_load;
    logic pb_we, pb_clr, pb_rvalid, pb_any, ram_we;
    logic [7:0] pb_rdata, ram_rdata, load_byte;
    logic [15:0] full_addr;

    tw_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
    tw_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

    tw_page_buf #(.DEPTH(SECT_SIZE), .W(8)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .widx(q.addr[OFF_W-1:0]), .wdata(q.sh), .ridx(q.tmr[OFF_W-1:0]),
        .rdata(pb_rdata), .rvalid(pb_rvalid), .any(pb_any));

    tw_sector_ram #(.AW(ADDR_W), .W(8)) u_ram (
        .clk(clk), .we(ram_we),
        .waddr({q.addr[ADDR_W-1:OFF_W], q.tmr[OFF_W-1:0]}),
        .wdata(pb_rdata), .raddr(q.addr), .rdata(ram_rdata));

    assign rise      = scl_f & ~q.sclp;
    assign fall      = ~scl_f & q.sclp;
    assign start_ev  = scl_f & q.sclp & q.sdap & ~sda_f;
    assign stop_ev   = scl_f & q.sclp & ~q.sdap & sda_f;
    assign dev_hit   = (q.sh[7:4] == DEV_TYPE) && (q.sh[3:1] == sel_i);
    assign full_addr = {q.hi, q.sh};
    assign load_byte = q.regsel ? prot_val_i : ram_rdata;

    always_comb begin
        n        = q;
        n.sclp   = scl_f;
        n.sdap   = sda_f;
        do_load  = 1'b0;
        pb_we    = 1'b0;
        pb_clr   = 1'b0;
        ram_we   = 1'b0;
        if (q.busy) begin
            n.st   = S_IDLE;
            n.oe   = 1'b0;
            n.tmr  = q.tmr + 1'b1;
            ram_we = (q.tmr < TMR_W'(SECT_SIZE)) && pb_rvalid;
            if (q.tmr == TMR_W'(WR_CYCLES - 1)) begin
                n.busy = 1'b0;
                n.tmr  = '0;
                pb_clr = 1'b1;
            end
        end else if (start_ev) begin
            n.st    = S_DEV;
            n.cnt   = '0;
            n.ackph = 1'b0;
            n.oe    = 1'b0;
            pb_clr  = 1'b1;
        end else if (stop_ev) begin
            if (q.st == S_WDAT && pb_any && wr_allow_i && !q.regsel) begin
                n.busy = 1'b1;
                n.tmr  = '0;
            end else begin
                pb_clr = 1'b1;
            end
            n.st    = S_IDLE;
            n.oe    = 1'b0;
            n.ackph = 1'b0;
        end else begin
            unique case (q.st)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (!q.ackph) begin
                        if (rise) begin
                            n.sh  = {q.sh[6:0], sda_f};
                            n.cnt = q.cnt + 1'b1;
                        end else if (fall && q.cnt == 4'd8) begin
                            if (q.st == S_DEV && !dev_hit) begin
                                n.st = S_IDLE;
                            end else begin
                                n.oe    = 1'b1;
                                n.ackph = 1'b1;
                            end
                        end
                    end else if (fall) begin
                        n.oe    = 1'b0;
                        n.ackph = 1'b0;
                        n.cnt   = '0;
                        unique case (q.st)
                            S_DEV: begin
                                if (q.sh[0]) do_load = 1'b1;
                                else         n.st = S_AHI;
                            end
                            S_AHI: begin
                                n.hi = q.sh;
                                n.st = S_ALO;
                            end
                            S_ALO: begin
                                n.addr   = full_addr[ADDR_W-1:0];
                                n.regsel = (full_addr == 16'hFFFF);
                                pb_clr   = 1'b1;
                                n.st     = S_WDAT;
                            end
                            default: begin
                                pb_we = 1'b1;
                                n.addr[OFF_W-1:0] = q.addr[OFF_W-1:0] + 1'b1;
                            end
                        endcase
                    end
                end
                S_RDAT: begin
                    if (!q.ackph) begin
                        if (rise) begin
                            n.cnt = q.cnt + 1'b1;
                        end else if (fall) begin
                            if (q.cnt == 4'd8) begin
                                n.oe    = 1'b0;
                                n.ackph = 1'b1;
                            end else begin
                                n.sh = {q.sh[6:0], 1'b0};
                                n.oe = ~q.sh[6];
                            end
                        end
                    end else begin
                        if (rise) begin
                            n.mack = ~sda_f;
                        end else if (fall) begin
                            if (q.mack) begin
                                do_load = 1'b1;
                            end else begin
                                n.st    = S_WAIT;
                                n.ackph = 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
        if (do_load) begin
            n.sh     = load_byte;
            n.oe     = ~load_byte[7];
            n.addr   = q.regsel ? '0 : q.addr + 1'b1;
            n.regsel = 1'b0;
            n.st     = S_RDAT;
            n.cnt    = '0;
            n.ackph  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.sclp <= 1'b1;
            q.sdap <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o     = q.oe;
    assign chk_sector_o = q.addr[ADDR_W-1:OFF_W];

    // R4: the bus stays released for the whole write cycle
    assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !sda_oe_o);
    // R4: a busy slave holds the protocol engine idle
    assert_deaf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> (q.st == S_IDLE));
    // R11: the data line only moves while the filtered clock is low
    assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_f);
    // R3: the sector number is frozen while program data arrives
    assert_sector_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WDAT && $past(q.st) == S_WDAT) |-> $stable(q.addr[ADDR_W-1:OFF_W]));
endmodule

// File: tb/tw_sector_slave_tb.sv
module tw_sector_slave_tb;
    localparam int HP     = 12;
    localparam int AW     = 10;
    localparam int AMASK  = (1 << AW) - 1;
    localparam int WRC    = 64;
    localparam logic [7:0] DEVW = 8'hAA;
    localparam logic [7:0] DEVR = 8'hAB;

    logic clk = 1'b0;
    logic rst_n;
    logic scl_m, sda_m, scl_glitch, allow;
    logic [7:0] prot;
    logic sda_oe;
    logic [AW-6:0] sector;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [0:AMASK];
    logic [7:0] rbuf [0:63];
    logic ack;
    logic [7:0] b;

    always #10 clk = ~clk;

    tw_sector_slave #(.ADDR_W(AW), .WR_CYCLES(WRC), .FILT_LEN(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m & ~scl_glitch), .sda_i(sda_bus),
        .sel_i(3'b101), .prot_val_i(prot), .wr_allow_i(allow),
        .sda_oe_o(sda_oe), .chk_sector_o(sector));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bstop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit gl, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = v[i]; hp(); scl_m = 1'b1;
            if (gl && i == 4) begin
                repeat (HP / 2) @(negedge clk);
                scl_glitch = 1'b1; @(negedge clk); scl_glitch = 1'b0;
                repeat (HP / 2 - 1) @(negedge clk);
            end else hp();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
        a = ~sda_bus;
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic s0;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl_m = 1'b1; @(negedge clk); s0 = sda_bus;
            hp(); v[i] = sda_bus;
            check(s0 == v[i], "R11 data stable while clock high", int'(v[i]), int'(s0));
            scl_m = 1'b0;
        end
        sda_m = ~mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
        @(negedge clk); sda_m = 1'b1;
    endtask

    task automatic model_prog(input int a, input int cnt, input logic [7:0] base);
        for (int k = 0; k < cnt; k++)
            exp_mem[(a & AMASK & ~31) | ((a + k) & 31)] = base + 8'(k);
    endtask

    task automatic send_addr(input logic [15:0] a, input string req);
        logic a1, a2, a3;
        bstart();
        send_byte(DEVW, 1'b0, a1); send_byte(a[15:8], 1'b0, a2); send_byte(a[7:0], 1'b0, a3);
        check(a1 && a2 && a3, req, {a1, a2, a3}, 7);
    endtask

    task automatic prog(input logic [15:0] a, input int cnt, input logic [7:0] base);
        int nak;
        nak = 0;
        send_addr(a, "R2 address bytes acknowledged");
        for (int k = 0; k < cnt; k++) begin
            send_byte(base + 8'(k), 1'b0, ack);
            if (!ack) nak++;
        end
        check(nak == 0, "R3 every data byte acknowledged", nak, 0);
        bstop();
    endtask

    task automatic rand_read(input logic [15:0] a, input int cnt);
        logic ar;
        send_addr(a, "R2 address bytes acknowledged");
        bstart();
        send_byte(DEVR, 1'b0, ar);
        check(ar, "R1 read device byte acknowledged", ar, 1);
        for (int k = 0; k < cnt; k++) recv_byte(k != cnt - 1, rbuf[k]);
    endtask

    task automatic cur_read(output logic [7:0] v);
        logic ar;
        bstart();
        send_byte(DEVR, 1'b0, ar);
        check(ar, "R1 read device byte acknowledged", ar, 1);
        recv_byte(1'b0, v);
        bstop();
    endtask

    task automatic poll(output logic a);
        bstart(); send_byte(DEVW, 1'b0, a); bstop();
    endtask

    task automatic settle();
        repeat (3 * WRC) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        scl_m = 1'b1; sda_m = 1'b1; scl_glitch = 1'b0; allow = 1'b1; prot = 8'h5A;
        rst_n = 1'b0;
        for (int i = 0; i <= AMASK; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset releases data line", sda_oe, 0);

        // R1: select sweep, then wrong type nibbles
        for (int t = 0; t < 8; t++) begin
            bstart(); send_byte({4'b1010, 3'(t), 1'b0}, 1'b0, ack); bstop();
            check(ack == (t == 5), "R1 select code match", ack, int'(t == 5));
        end
        for (int t = 0; t < 4; t++) begin
            logic [3:0] ty;
            ty = (t == 0) ? 4'b1011 : (t == 1) ? 4'b0010 : (t == 2) ? 4'b1110 : 4'b0101;
            bstart(); send_byte({ty, 3'b101, 1'b0}, 1'b0, ack); bstop();
            check(!ack, "R1 wrong type not acknowledged", ack, 0);
        end

        // R4: program and acknowledge polling
        prog(16'h0060, 32, 8'h30);
        model_prog(16'h0060, 32, 8'h30);
        poll(ack);
        check(!ack, "R4 no acknowledge during write cycle", ack, 0);
        settle();
        poll(ack);
        check(ack, "R4 acknowledge after write cycle", ack, 1);
        rand_read(16'h0060, 32); bstop();
        for (int k = 0; k < 32; k++)
            check(rbuf[k] == exp_mem[16'h60 + k], "R4 written sector reads back", rbuf[k], exp_mem[16'h60 + k]);

        // R3: offset wraps inside sector, later byte wins
        prog(16'h00BE, 34, 8'hA0);
        model_prog(16'h00BE, 34, 8'hA0);
        settle();
        cur_read(b);
        check(b == exp_mem[16'hA0], "R3 counter after program wraps in sector", b, exp_mem[16'hA0]);
        rand_read(16'h00A0, 32); bstop();
        for (int k = 0; k < 32; k++)
            check(rbuf[k] == exp_mem[16'hA0 + k], "R3 sector wrap content", rbuf[k], exp_mem[16'hA0 + k]);

        // R6: sequential read wraps across the array end
        prog(16'h03E0, 32, 8'h40); model_prog(16'h03E0, 32, 8'h40); settle();
        prog(16'h0000, 32, 8'h90); model_prog(16'h0000, 32, 8'h90); settle();
        rand_read(16'h03FE, 4);
        for (int k = 0; k < 4; k++)
            check(rbuf[k] == exp_mem[(16'h3FE + k) & AMASK], "R6 sequential read with wrap",
                  rbuf[k], exp_mem[(16'h3FE + k) & AMASK]);

        // R7: after master no-acknowledge the line stays released
        sda_m = 1'b1;
        for (int p = 0; p < 3; p++) begin
            hp(); scl_m = 1'b1; hp();
            check(sda_bus == 1'b1 && sda_oe == 1'b0, "R7 released after no-acknowledge", sda_oe, 0);
            scl_m = 1'b0;
        end
        bstop();

        // R2: set current address with a stop
        send_addr(16'h0065, "R2 address bytes acknowledged"); bstop();
        cur_read(b);
        check(b == exp_mem[16'h65], "R2 set current address", b, exp_mem[16'h65]);

        // R8: protection value at FFFFh, counter then 0
        for (int t = 0; t < 2; t++) begin
            prot = (t == 0) ? 8'h5A : 8'hC3;
            rand_read(16'hFFFF, 1); bstop();
            check(rbuf[0] == prot, "R8 read at FFFFh returns protection value", rbuf[0], prot);
            cur_read(b);
            check(b == exp_mem[0], "R8 counter is 0 after FFFFh read", b, exp_mem[0]);
        end

        // R5: program not allowed
        allow = 1'b0;
        prog(16'h0060, 2, 8'hEE);
        poll(ack);
        check(ack, "R5 no write cycle when not allowed", ack, 1);
        allow = 1'b1;
        rand_read(16'h0060, 2); bstop();
        for (int k = 0; k < 2; k++)
            check(rbuf[k] == exp_mem[16'h60 + k], "R5 memory unchanged", rbuf[k], exp_mem[16'h60 + k]);

        // R9: repeated start aborts a program
        send_addr(16'h0061, "R2 address bytes acknowledged");
        for (int k = 0; k < 3; k++) send_byte(8'h11, 1'b0, ack);
        bstart(); bstop();
        poll(ack);
        check(ack, "R9 no write cycle after aborted program", ack, 1);
        rand_read(16'h0061, 3); bstop();
        for (int k = 0; k < 3; k++)
            check(rbuf[k] == exp_mem[16'h61 + k], "R9 memory unchanged after abort", rbuf[k], exp_mem[16'h61 + k]);

        // R10: one-clock glitch on the bus clock is ignored
        send_addr(16'h0070, "R2 address bytes acknowledged"); bstop();
        bstart(); send_byte(DEVR, 1'b1, ack);
        check(ack, "R10 device byte with clock glitch acknowledged", ack, 1);
        recv_byte(1'b0, b); bstop();
        check(b == exp_mem[16'h70], "R10 data correct after clock glitch", b, exp_mem[16'h70]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule